// File: doc/BRIEF.md
# Floating-Point Access and Alignment Fault Gate

This block sits next to instruction dispatch. For each operation it decides whether the operation must trap, and which trap it takes. It looks at the current system-control mode bits, the alignment flag, the privilege level and the operand address and size. It also tracks a pending numeric error that the floating-point unit reports.

It can raise three things:
- a coprocessor-unavailable fault,
- an alignment fault,
- a numeric-error exception request.

When error reporting is in the external style, the block does not raise the exception. Instead it either drops the error or freezes dispatch. While frozen it holds an active-low error pin low for an external interrupt controller, until an interrupt arrives.

Fault outputs are combinational in the issue cycle. The stall request and the error pin are registered and change on the edge after the event that causes them.

Top module: `fp_access_guard`

## Requirements
- R1: A numeric operation (`op_kind_i` = 1) issued while `emul_i` is set raises `nm_fault_o` in the same cycle.
- R2: A numeric operation issued while `task_sw_i` is set raises `nm_fault_o`. A WAIT operation (`op_kind_i` = 2) raises it only when `mon_coproc_i` and `task_sw_i` are both set, and `emul_i` has no effect on WAIT. Kind 0 and kind 3 are ordinary integer operations.
- R3: `ac_fault_o` can be raised only for a memory access (`mem_access_i` = 1) with `align_en_i` set, `align_flag_i` set and `cpl_i` = 3. If any one of these is missing, no alignment fault is raised.
- R4: `size_i` encodes the operand width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. An access is misaligned when any of the low log2(bytes) bits of `addr_i` is non-zero. A 1-byte access is never misaligned.
- R5: At most one of `nm_fault_o`, `ac_fault_o` and `mf_req_o` is high. The order of precedence is coprocessor-unavailable, then alignment, then numeric error.
- R6: A pulse on `fpu_err_set_i` makes a numeric error pending from the next cycle onward. It stays pending until a pulse on `fpu_err_clr_i`. With `num_err_int_i` set, a numeric or WAIT operation that issues while an error is pending, and has no higher fault, raises `mf_req_o` in the same cycle. Integer operations never report it.
- R7: With `num_err_int_i` clear and `ign_err_i` set, a pending error is ignored. No `mf_req_o` is raised, `stall_o` stays low and `err_n_o` stays high.
- R8: With `num_err_int_i` and `ign_err_i` both clear, a numeric or WAIT operation that meets a pending error raises no `mf_req_o`. From the next edge, `stall_o` is high and `err_n_o` is low.
- R9: While `stall_o` is high, issued operations raise no fault of any kind. The first clock edge with `irq_i` high clears `stall_o`.
- R10: Once low, `err_n_o` stays low until a pulse on `fpu_err_clr_i`, even after the stall has been released. It returns high on the edge after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An operation issues this cycle |
| op_kind_i | input | 2 | 0 integer, 1 numeric, 2 WAIT, 3 integer |
| mem_access_i | input | 1 | Operation accesses memory |
| addr_i | input | 32 | Operand linear address |
| size_i | input | 2 | Operand width code (1/2/4/8 bytes) |
| emul_i | input | 1 | Numeric emulation mode bit |
| task_sw_i | input | 1 | Task-switched bit |
| mon_coproc_i | input | 1 | WAIT obeys the task-switched bit |
| num_err_int_i | input | 1 | Report numeric errors internally |
| align_en_i | input | 1 | Alignment-check mask bit |
| align_flag_i | input | 1 | Alignment flag from the flags register |
| cpl_i | input | 2 | Current privilege level |
| ign_err_i | input | 1 | External ignore-numeric-error input, active high |
| fpu_err_set_i | input | 1 | Floating-point unit signals a new numeric error |
| fpu_err_clr_i | input | 1 | Numeric error status cleared |
| irq_i | input | 1 | Interrupt signalled to the core |
| nm_fault_o | output | 1 | Coprocessor-unavailable fault |
| ac_fault_o | output | 1 | Alignment-check fault |
| mf_req_o | output | 1 | Numeric-error exception request |
| stall_o | output | 1 | Freeze dispatch until an interrupt |
| err_n_o | output | 1 | External numeric error pin, active low |

## Verification
The hardest state to reach from the ports is a frozen core whose error pin must outlive the freeze. Getting there takes three steps:
1. Inject an error with a pulse.
2. Issue a numeric operation with both internal reporting and the ignore input off.
3. Release the freeze with an interrupt.

The stimulus then issues an operation that would otherwise fault while still frozen. It pulses the interrupt and confirms that the pin stays low until the clear pulse. The same pending error is reused under the other two reporting modes, and with a higher-priority fault present, to exercise every branch of the reporting path.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    OP_INT  = 2'd0,
    OP_NUM  = 2'd1,
    OP_WAIT = 2'd2,
    OP_RSVD = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic emul;
    logic task_sw;
    logic mon_coproc;
  } fp_mode_t;

  typedef struct packed {
    logic en;
    logic flag;
  } align_ctl_t;
endpackage

// File: rtl/fpg_avail_chk.sv
module fpg_avail_chk
  import fpg_pkg::*;
(
  input  op_kind_e op_kind_i,
  input  fp_mode_t mode_i,
  output logic     fp_like_o,
  output logic     unavail_o
);
  logic is_num, is_wait;

  always_comb begin
    is_num    = (op_kind_i == OP_NUM);
    is_wait   = (op_kind_i == OP_WAIT);
    fp_like_o = is_num | is_wait;
    unavail_o = 1'b0;
    if (is_num)
      unavail_o = mode_i.emul | mode_i.task_sw;
    else if (is_wait)
      unavail_o = mode_i.mon_coproc & mode_i.task_sw;
  end
endmodule

// File: rtl/fpg_align_chk.sv
module fpg_align_chk
  import fpg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 2,
  parameter int CPL_W    = 2,
  parameter int USER_CPL = 3
) (
  input  logic              mem_access_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  align_ctl_t        ctl_i,
  input  logic [CPL_W-1:0]  cpl_i,
  output logic              hit_o
);
  localparam int NSIZE = 1 << SIZE_W;
  localparam int LOW_W = NSIZE - 1;

  logic [LOW_W-1:0] size_mask [NSIZE];

  // mask g covers the low g address bits (operand of 2**g bytes)
  for (genvar g = 0; g < NSIZE; g++) begin : g_mask
    assign size_mask[g] = {LOW_W{1'b1}} >> (LOW_W - g);
  end

  logic misaligned, qualified;

  always_comb begin
    misaligned = |(addr_i[LOW_W-1:0] & size_mask[size_i]);
    qualified  = mem_access_i & ctl_i.en & ctl_i.flag &
                 (cpl_i == CPL_W'(USER_CPL));
    hit_o      = qualified & misaligned;
  end
endmodule

// File: rtl/fpg_nerr_ctl.sv
module fpg_nerr_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_set_i,
  input  logic err_clr_i,
  input  logic int_mode_i,
  input  logic ign_i,
  input  logic irq_i,
  input  logic check_i,
  output logic report_o,
  output logic stall_o,
  output logic err_n_o
);
  logic pend_q, stall_q, pin_q;
  logic meet, freeze;

  always_comb begin
    meet     = check_i & pend_q;
    report_o = meet & int_mode_i;
    freeze   = meet & ~int_mode_i & ~ign_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      stall_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (err_set_i)      pend_q <= 1'b1;
      else if (err_clr_i) pend_q <= 1'b0;

      if (freeze)         stall_q <= 1'b1;
      else if (irq_i)     stall_q <= 1'b0;

      if (err_clr_i)      pin_q <= 1'b0;
      else if (freeze)    pin_q <= 1'b1;
    end
  end

  assign stall_o = stall_q;
  assign err_n_o = ~pin_q;
endmodule

// File: rtl/fp_access_guard.sv
module fp_access_guard
  import fpg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 2,
  parameter int CPL_W    = 2,
  parameter int USER_CPL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic              mem_access_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              emul_i,
  input  logic              task_sw_i,
  input  logic              mon_coproc_i,
  input  logic              num_err_int_i,
  input  logic              align_en_i,
  input  logic              align_flag_i,
  input  logic [CPL_W-1:0]  cpl_i,
  input  logic              ign_err_i,
  input  logic              fpu_err_set_i,
  input  logic              fpu_err_clr_i,
  input  logic              irq_i,
  output logic              nm_fault_o,
  output logic              ac_fault_o,
  output logic              mf_req_o,
  output logic              stall_o,
  output logic              err_n_o
);
  fp_mode_t   mode;
  align_ctl_t actl;
  op_kind_e   kind;
  logic fp_like, unavail, align_hit, act, chk, report, stalled;

  assign mode = '{emul: emul_i, task_sw: task_sw_i, mon_coproc: mon_coproc_i};
  assign actl = '{en: align_en_i, flag: align_flag_i};
  assign kind = op_kind_e'(op_kind_i);

  fpg_avail_chk u_avail (
    .op_kind_i (kind),
    .mode_i    (mode),
    .fp_like_o (fp_like),
    .unavail_o (unavail)
  );

  fpg_align_chk #(
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W),
    .CPL_W   (CPL_W),
    .USER_CPL(USER_CPL)
  ) u_align (
    .mem_access_i(mem_access_i),
    .addr_i      (addr_i),
    .size_i      (size_i),
    .ctl_i       (actl),
    .cpl_i       (cpl_i),
    .hit_o       (align_hit)
  );

  // priority: unavailable > alignment > numeric error
  always_comb begin
    act        = issue_valid_i & ~stalled;
    nm_fault_o = act & unavail;
    ac_fault_o = act & ~unavail & align_hit;
    chk        = act & fp_like & ~unavail & ~align_hit;
    mf_req_o   = report;
  end

  fpg_nerr_ctl u_nerr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_set_i (fpu_err_set_i),
    .err_clr_i (fpu_err_clr_i),
    .int_mode_i(num_err_int_i),
    .ign_i     (ign_err_i),
    .irq_i     (irq_i),
    .check_i   (chk),
    .report_o  (report),
    .stall_o   (stalled),
    .err_n_o   (err_n_o)
  );

  assign stall_o = stalled;
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int CPL_W    = 2,
  parameter int USER_CPL = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic [1:0]       op_kind_i,
  input logic             emul_i,
  input logic [CPL_W-1:0] cpl_i,
  input logic             num_err_int_i,
  input logic             ign_err_i,
  input logic             fpu_err_clr_i,
  input logic             irq_i,
  input logic             nm_fault_o,
  input logic             ac_fault_o,
  input logic             mf_req_o,
  input logic             stall_o,
  input logic             err_n_o
);
  // R1
  emul_num_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !stall_o && op_kind_i == 2'd1 && emul_i) |-> nm_fault_o);

  // R3
  user_only_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_i != CPL_W'(USER_CPL)) |-> !ac_fault_o);

  // R5
  single_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nm_fault_o, ac_fault_o, mf_req_o}));

  // R7
  ignore_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!num_err_int_i && ign_err_i && !stall_o) |=> !$rose(stall_o));

  // R8
  stall_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> !err_n_o);

  // R9
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !(nm_fault_o || ac_fault_o || mf_req_o));

  // R9
  stall_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && irq_i) |=> !stall_o);

  // R10
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_n_o && !fpu_err_clr_i) |=> !err_n_o);
endmodule

bind fp_access_guard fpg_checker #(.CPL_W(CPL_W), .USER_CPL(USER_CPL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .op_kind_i    (op_kind_i),
  .emul_i       (emul_i),
  .cpl_i        (cpl_i),
  .num_err_int_i(num_err_int_i),
  .ign_err_i    (ign_err_i),
  .fpu_err_clr_i(fpu_err_clr_i),
  .irq_i        (irq_i),
  .nm_fault_o   (nm_fault_o),
  .ac_fault_o   (ac_fault_o),
  .mf_req_o     (mf_req_o),
  .stall_o      (stall_o),
  .err_n_o      (err_n_o)
);

// File: tb/fp_access_guard_tb.sv
module fp_access_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic mem_access = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0] size = 2'd0;
  logic emul = 1'b0, task_sw = 1'b0, mon_coproc = 1'b0, num_err_int = 1'b0;
  logic align_en = 1'b0, align_flag = 1'b0;
  logic [1:0] cpl = 2'd0;
  logic ign_err = 1'b0, err_set = 1'b0, err_clr = 1'b0, irq = 1'b0;
  logic nm_fault, ac_fault, mf_req, stall, err_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fp_access_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(issue_valid),
    .op_kind_i(op_kind), .mem_access_i(mem_access), .addr_i(addr),
    .size_i(size), .emul_i(emul), .task_sw_i(task_sw),
    .mon_coproc_i(mon_coproc), .num_err_int_i(num_err_int),
    .align_en_i(align_en), .align_flag_i(align_flag), .cpl_i(cpl),
    .ign_err_i(ign_err), .fpu_err_set_i(err_set), .fpu_err_clr_i(err_clr),
    .irq_i(irq), .nm_fault_o(nm_fault), .ac_fault_o(ac_fault),
    .mf_req_o(mf_req), .stall_o(stall), .err_n_o(err_n)
  );

  // {kind[2], mem, addr[3], size[2], em ts mp am ac, cpl[2], exp nm ac mf}
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 1'b0, 3'd0, 2'd0, 5'b10000, 2'd0, 3'b100}, // R1 numeric + emul
    {2'd1, 1'b0, 3'd0, 2'd0, 5'b01000, 2'd0, 3'b100}, // R2 numeric + task_sw
    {2'd1, 1'b0, 3'd0, 2'd0, 5'b00100, 2'd0, 3'b000}, // R2 numeric clean
    {2'd2, 1'b0, 3'd0, 2'd0, 5'b10000, 2'd0, 3'b000}, // R2 wait ignores emul
    {2'd2, 1'b0, 3'd0, 2'd0, 5'b01000, 2'd0, 3'b000}, // R2 wait, mp clear
    {2'd2, 1'b0, 3'd0, 2'd0, 5'b01100, 2'd0, 3'b100}, // R2 wait, mp+ts
    {2'd0, 1'b1, 3'd1, 2'd2, 5'b00011, 2'd3, 3'b010}, // R3 all qualifiers
    {2'd0, 1'b1, 3'd1, 2'd2, 5'b00011, 2'd2, 3'b000}, // R3 cpl 2
    {2'd0, 1'b1, 3'd1, 2'd2, 5'b00001, 2'd3, 3'b000}, // R3 mask off
    {2'd0, 1'b1, 3'd1, 2'd2, 5'b00010, 2'd3, 3'b000}, // R3 flag off
    {2'd0, 1'b0, 3'd1, 2'd2, 5'b00011, 2'd3, 3'b000}, // R3 no memory access
    {2'd0, 1'b1, 3'd3, 2'd0, 5'b00011, 2'd3, 3'b000}, // R4 byte never misaligned
    {2'd0, 1'b1, 3'd2, 2'd1, 5'b00011, 2'd3, 3'b000}, // R4 word aligned
    {2'd0, 1'b1, 3'd1, 2'd1, 5'b00011, 2'd3, 3'b010}, // R4 word odd
    {2'd3, 1'b1, 3'd4, 2'd3, 5'b00011, 2'd3, 3'b010}, // R4 8-byte at 4
    {2'd1, 1'b1, 3'd2, 2'd2, 5'b10011, 2'd3, 3'b100}  // R5 unavail over align
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    issue_valid = 1'b0; op_kind = 2'd0; mem_access = 1'b0; addr = '0;
    size = 2'd0; emul = 1'b0; task_sw = 1'b0; mon_coproc = 1'b0;
    align_en = 1'b0; align_flag = 1'b0; cpl = 2'd0;
  endtask

  task automatic pulse_set();
    @(negedge clk); err_set = 1'b1;
    @(negedge clk); err_set = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic issue_num();
    @(negedge clk); issue_valid = 1'b1; op_kind = 2'd1;
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #9;
    check("reset stall", {31'd0, stall}, 32'd0);
    check("reset err pin", {31'd0, err_n}, 32'd1);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issue_valid = 1'b1;
      op_kind = VEC[i][17:16]; mem_access = VEC[i][15];
      addr = 32'h4000_0000 | {29'd0, VEC[i][14:12]};
      size = VEC[i][11:10];
      {emul, task_sw, mon_coproc, align_en, align_flag} = VEC[i][9:5];
      cpl = VEC[i][4:3];
      #1;
      check($sformatf("vec %0d (R1 R2 R3 R4 R5)", i),
            {29'd0, nm_fault, ac_fault, mf_req}, {29'd0, VEC[i][2:0]});
    end
    @(negedge clk); idle();

    // R6 internal reporting
    num_err_int = 1'b1;
    pulse_set();
    issue_num();
    check("R6 mf on numeric", {31'd0, mf_req}, 32'd1);
    @(negedge clk); op_kind = 2'd0; #1;
    check("R6 integer not reported", {31'd0, mf_req}, 32'd0);
    @(negedge clk); op_kind = 2'd1; emul = 1'b1; #1;
    check("R5 unavail beats mf", {30'd0, nm_fault, mf_req}, 32'd2);
    @(negedge clk); idle(); #1;
    check("R6 no stall internal", {31'd0, stall}, 32'd0);

    // R7 ignore path, error still pending
    num_err_int = 1'b0; ign_err = 1'b1;
    issue_num();
    check("R7 ignored no mf", {31'd0, mf_req}, 32'd0);
    @(negedge clk); idle(); #1;
    check("R7 no stall, pin high", {30'd0, stall, err_n}, 32'd1);

    // R8 freeze path
    ign_err = 1'b0;
    issue_num();
    check("R8 no mf", {31'd0, mf_req}, 32'd0);
    @(negedge clk); idle(); #1;
    check("R8 stall and pin", {30'd0, stall, err_n}, 32'd2);

    // R9 issue while stalled is ignored
    @(negedge clk); issue_valid = 1'b1; op_kind = 2'd1; emul = 1'b1; #1;
    check("R9 quiet while stalled", {29'd0, nm_fault, ac_fault, mf_req}, 32'd0);
    @(negedge clk); idle(); irq = 1'b1;
    @(negedge clk); irq = 1'b0; #1;
    check("R9 released by irq", {31'd0, stall}, 32'd0);
    check("R10 pin held after release", {31'd0, err_n}, 32'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R10 pin still held", {31'd0, err_n}, 32'd0);
    pulse_clr();
    #1;
    check("R10 pin released by clear", {31'd0, err_n}, 32'd1);

    // R6 cleared error no longer reported
    num_err_int = 1'b1;
    issue_num();
    check("R6 cleared not reported", {31'd0, mf_req}, 32'd0);
    @(negedge clk); idle();
    finish_run();
  end
endmodule